// File: doc/BRIEF.md
# Pend-Post Interrupt Controller

This block gathers up to 32 interrupt lines and hands the CPU one request at a time. Every line has two candidate sources: a fixed-function event and a DMA-termination event. A per-line selector picks which of the two feeds the line. A rising edge on the selected source marks the line pending. One clock later, the pending line is posted into arbitration, provided the line is enabled. One clock after that, the controller raises its request to the CPU and drives the number of the winning line alongside it.

Each line has a 3-bit priority, where 0 is the most urgent. When priorities tie, the lower line number wins. The CPU acknowledges the request it sees. That clears the line's pending bit and pushes the line onto a nesting stack, whose top entry is reported as the active interrupt. While an interrupt is active, only a pending line of strictly more urgent priority can raise a new request. An end-of-interrupt pulse pops the stack and so returns to the level that was active before.

Top module: `irq_pend_post_ctrl`

## Requirements
- R1: A rising edge on a line's selected source, sampled at a clock edge, sets that line's pending state at that same edge. A source that stays low or stays high sets nothing.
- R2: The request is clock-aligned in stages. Pending is set at edge 1. The line is posted at edge 2. `irq` rises, with `irq_num` equal to the line, at edge 3 after the source is first sampled high, and not earlier.
- R3: `src_sel[i]` = 1 takes line i from `src_dma[i]`; `src_sel[i]` = 0 takes it from `src_fixed[i]`. Edges on the unselected input produce no request.
- R4: Priority field i occupies `line_prio[3*i+2 : 3*i]`. Value 0 is the most urgent. Among posted lines, the most urgent one wins, and equal priorities go to the lowest line number.
- R5: A line whose `line_en` bit is 0 still becomes pending but is never posted. Setting the bit later posts it, and `irq` follows two edges after the enable is sampled.
- R6: `cpu_ack` sampled high while `irq` is high does three things at that edge: it clears the pending state of line `irq_num`, drops `irq`, and sets `act_valid` = 1 with `act_num` = that line. `cpu_ack` while `irq` is low has no effect.
- R7: A rising edge on the acknowledged line during the acknowledge cycle leaves that line pending again.
- R8: While an interrupt is active, `irq` is raised only for a posted line whose priority value is strictly lower than the active line's.
- R9: `cpu_eoi` pops the active interrupt. `act_num` returns to the previously active line, or `act_valid` goes to 0 when no earlier interrupt remains. An end-of-interrupt pulse in a cycle that also acknowledges is ignored.
- R10: Synchronous active-low reset clears all pending and posted state and the nesting stack. After reset, `irq` and `act_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_fixed | input | 32 | Fixed-function source per line |
| src_dma | input | 32 | DMA-termination source per line |
| src_sel | input | 32 | Source selector per line (1 = DMA source) |
| line_en | input | 32 | Per-line enable for posting |
| line_prio | input | 96 | Per-line 3-bit priority, packed by line index |
| cpu_ack | input | 1 | CPU acknowledge of the current request |
| cpu_eoi | input | 1 | End of the active interrupt |
| irq | output | 1 | Request to the CPU |
| irq_num | output | 5 | Line number of the request |
| act_valid | output | 1 | An interrupt is active |
| act_num | output | 5 | Line number of the active interrupt |

## Verification
A source edge driven before a clock edge shows up as `irq` only after the third edge. The bench therefore samples at the falling edge after the second edge, expecting no request, and again after the third, expecting the request and its number. Acknowledge and end-of-interrupt act at the very next edge, so `act_valid`, `act_num` and the dropped `irq` are checked one falling edge after the pulse. A request that must wait for an end-of-interrupt is expected to be absent after the pop edge and present one edge later, because the request register is computed from the level held before the pop. Enabling a pending line is checked the same way: nothing after one edge, the request after two.

// File: rtl/irq_pp_pkg.sv
// Shared definitions for the pend-post interrupt controller.
// Assumes: consumers size their own vectors from the parameters below.
package irq_pp_pkg;
    localparam int LINES_DEF = 32;
    localparam int PRIO_W_DEF = 3;

    // Operation applied to the nesting stack in one cycle
    typedef enum logic [1:0] {
        STK_HOLD = 2'd0,
        STK_PUSH = 2'd1,
        STK_POP  = 2'd2
    } stk_op_e;
endpackage

// File: rtl/irq_pp_capture.sv
// Source selection, rising-edge detection, pending latches and posting stage.
// Assumes: sources are synchronous to clk; one line at most is cleared per cycle.
module irq_pp_capture #(
    parameter int N_LINES = 32,
    parameter int IDX_W   = $clog2(N_LINES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] src_fixed,
    input  logic [N_LINES-1:0] src_dma,
    input  logic [N_LINES-1:0] src_sel,
    input  logic [N_LINES-1:0] line_en,
    input  logic               clr_vld,
    input  logic [IDX_W-1:0]   clr_idx,
    output logic [N_LINES-1:0] pend_o,
    output logic [N_LINES-1:0] post_o
);
    logic [N_LINES-1:0] src_cur;
    logic [N_LINES-1:0] src_q;
    logic [N_LINES-1:0] rise;
    logic [N_LINES-1:0] clr_mask;

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        // Pick the source feeding this line
        assign src_cur[g]  = src_sel[g] ? src_dma[g] : src_fixed[g];
        // One-hot clear for the acknowledged line
        assign clr_mask[g] = clr_vld && (clr_idx == IDX_W'(g));
    end

    assign rise = src_cur & ~src_q;

    // Remember last sampled source level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) src_q <= '0;
        else        src_q <= src_cur;
    end

    // Pending latch: an edge sets, acknowledge clears, an edge wins over clear
    always_ff @(posedge clk) begin
        if (!rst_n) pend_o <= '0;
        else        pend_o <= (pend_o & ~clr_mask) | rise;
    end

    // Posting stage: enabled pending lines enter arbitration one cycle later
    always_ff @(posedge clk) begin
        if (!rst_n) post_o <= '0;
        else        post_o <= pend_o & line_en & ~clr_mask;
    end
endmodule

// File: rtl/irq_pp_arbiter.sv
// Combinational priority resolution over posted lines with a preemption gate.
// Assumes: smaller priority value is more urgent; ties go to the lower index.
module irq_pp_arbiter #(
    parameter int N_LINES = 32,
    parameter int PRIO_W  = 3,
    parameter int IDX_W   = $clog2(N_LINES)
) (
    input  logic [N_LINES-1:0]        post,
    input  logic [N_LINES*PRIO_W-1:0] prio_flat,
    input  logic                      act_valid,
    input  logic [PRIO_W-1:0]         act_prio,
    output logic                      req,
    output logic [IDX_W-1:0]          win_idx
);
    logic              best_v;
    logic [PRIO_W-1:0] best_p;

    // Scan from the top index down so equal priorities settle on the lowest line
    always_comb begin
        best_v  = 1'b0;
        best_p  = '1;
        win_idx = '0;
        for (int i = N_LINES - 1; i >= 0; i--) begin
            if (post[i] && (!best_v || prio_flat[i*PRIO_W +: PRIO_W] <= best_p)) begin
                best_v  = 1'b1;
                best_p  = prio_flat[i*PRIO_W +: PRIO_W];
                win_idx = IDX_W'(i);
            end
        end
    end

    // Only a strictly more urgent line may interrupt the active one
    assign req = best_v && (!act_valid || (best_p < act_prio));
endmodule

// File: rtl/irq_pp_nest.sv
// Nesting stack of acknowledged interrupts; top entry is the active one.
// Assumes: depth equals the number of priority levels, so strict preemption
// can never push more entries than it holds.
module irq_pp_nest
    import irq_pp_pkg::*;
#(
    parameter int PRIO_W = 3,
    parameter int IDX_W  = 5,
    parameter int DEPTH  = 2**PRIO_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  stk_op_e           op,
    input  logic [IDX_W-1:0]  push_num,
    input  logic [PRIO_W-1:0] push_prio,
    output logic              act_valid,
    output logic [IDX_W-1:0]  act_num,
    output logic [PRIO_W-1:0] act_prio
);
    localparam int SW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [IDX_W-1:0]  num_mem  [DEPTH];
    logic [PRIO_W-1:0] prio_mem [DEPTH];
    logic [CW-1:0]     cnt;
    logic [SW-1:0]     top_idx;

    assign top_idx   = cnt[SW-1:0] - SW'(1);
    assign act_valid = (cnt != '0);
    assign act_num   = num_mem[top_idx];
    assign act_prio  = prio_mem[top_idx];

    // Entry count: push on acknowledge, pop on end-of-interrupt
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else begin
            case (op)
                STK_PUSH: if (cnt < CW'(DEPTH)) cnt <= cnt + CW'(1);
                STK_POP:  if (cnt != '0)        cnt <= cnt - CW'(1);
                default:  cnt <= cnt;
            endcase
        end
    end

    // Entry storage written at the free slot on push
    always_ff @(posedge clk) begin
        if (op == STK_PUSH && cnt < CW'(DEPTH)) begin
            num_mem[cnt[SW-1:0]]  <= push_num;
            prio_mem[cnt[SW-1:0]] <= push_prio;
        end
    end
endmodule

// File: rtl/irq_pend_post_ctrl.sv
// Pend-post interrupt controller top: capture, arbitration, request register
// and nesting stack.
// Assumes: cpu_ack refers to the irq_num presented in the same cycle;
// an acknowledge takes precedence over a coincident end-of-interrupt.
module irq_pend_post_ctrl
    import irq_pp_pkg::*;
#(
    parameter int N_LINES = LINES_DEF,
    parameter int PRIO_W  = PRIO_W_DEF
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [N_LINES-1:0]          src_fixed,
    input  logic [N_LINES-1:0]          src_dma,
    input  logic [N_LINES-1:0]          src_sel,
    input  logic [N_LINES-1:0]          line_en,
    input  logic [N_LINES*PRIO_W-1:0]   line_prio,
    input  logic                        cpu_ack,
    input  logic                        cpu_eoi,
    output logic                        irq,
    output logic [$clog2(N_LINES)-1:0]  irq_num,
    output logic                        act_valid,
    output logic [$clog2(N_LINES)-1:0]  act_num
);
    localparam int IDX_W  = $clog2(N_LINES);
    localparam int NEST_D = 2**PRIO_W;

    logic [N_LINES-1:0] pend;
    logic [N_LINES-1:0] post;
    logic               req;
    logic [IDX_W-1:0]   win_idx;
    logic [PRIO_W-1:0]  act_prio;
    logic               ack_take;
    stk_op_e            stk_op;

    assign ack_take = cpu_ack && irq;

    // Stack operation chosen from the CPU handshake
    always_comb begin
        if (ack_take)     stk_op = STK_PUSH;
        else if (cpu_eoi) stk_op = STK_POP;
        else              stk_op = STK_HOLD;
    end

    irq_pp_capture #(.N_LINES(N_LINES), .IDX_W(IDX_W)) u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_fixed (src_fixed),
        .src_dma   (src_dma),
        .src_sel   (src_sel),
        .line_en   (line_en),
        .clr_vld   (ack_take),
        .clr_idx   (irq_num),
        .pend_o    (pend),
        .post_o    (post)
    );

    irq_pp_arbiter #(.N_LINES(N_LINES), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_arbiter (
        .post      (post),
        .prio_flat (line_prio),
        .act_valid (act_valid),
        .act_prio  (act_prio),
        .req       (req),
        .win_idx   (win_idx)
    );

    irq_pp_nest #(.PRIO_W(PRIO_W), .IDX_W(IDX_W), .DEPTH(NEST_D)) u_nest (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (stk_op),
        .push_num  (irq_num),
        .push_prio (line_prio[irq_num*PRIO_W +: PRIO_W]),
        .act_valid (act_valid),
        .act_num   (act_num),
        .act_prio  (act_prio)
    );

    // Request register: drops on acknowledge, otherwise follows arbitration
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq     <= 1'b0;
            irq_num <= '0;
        end else if (ack_take) begin
            irq     <= 1'b0;
        end else begin
            irq     <= req;
            irq_num <= win_idx;
        end
    end
endmodule

// File: rtl/irq_pp_checker.sv
// Temporal checks on the controller handshake and staging, bound to the top.
// Assumes: pend/post are the capture stage outputs of the bound instance.
module irq_pp_checker #(
    parameter int N_LINES = 32,
    parameter int IDX_W   = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cpu_ack,
    input logic [N_LINES-1:0] line_en,
    input logic               irq,
    input logic [IDX_W-1:0]   irq_num,
    input logic               act_valid,
    input logic [IDX_W-1:0]   act_num,
    input logic [N_LINES-1:0] pend,
    input logic [N_LINES-1:0] post
);
    // R6: an accepted acknowledge drops the request at the next edge
    p_ack_drops_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ack && irq) |=> !irq);

    // R6: an accepted acknowledge makes the requested line active
    p_ack_activates_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ack && irq) |=> (act_valid && act_num == $past(irq_num)));

    // R5: a line is posted only if it was pending and enabled one cycle before
    p_post_needs_pend_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((post & ~$past(pend & line_en)) == '0));

    // R2: a request is only raised from a line posted in the previous cycle
    p_irq_needs_post_r2: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ($past(post) != '0));

    // R9: with nothing active and no acknowledge, nothing becomes active
    p_idle_stays_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!act_valid && !(cpu_ack && irq)) |=> !act_valid);
endmodule

bind irq_pend_post_ctrl irq_pp_checker #(.N_LINES(N_LINES), .IDX_W(IDX_W)) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_ack   (cpu_ack),
    .line_en   (line_en),
    .irq       (irq),
    .irq_num   (irq_num),
    .act_valid (act_valid),
    .act_num   (act_num),
    .pend      (pend),
    .post      (post)
);

// File: tb/irq_pend_post_ctrl_tb_top.sv
`timescale 1ns/1ps
// Self-checking bench: vector table walk, then directed corner cases.
module irq_pend_post_ctrl_tb_top;
    localparam int NL = 32;
    localparam int PW = 3;

    typedef struct packed {
        logic [4:0] line;
        logic       sel;
        logic [2:0] prio;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VEC [NV] = '{
        '{5'd0,  1'b0, 3'd0},
        '{5'd31, 1'b1, 3'd7},
        '{5'd17, 1'b1, 3'd3},
        '{5'd8,  1'b0, 3'd5},
        '{5'd24, 1'b0, 3'd1},
        '{5'd1,  1'b1, 3'd6}
    };

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NL-1:0]  src_fixed = '0;
    logic [NL-1:0]  src_dma = '0;
    logic [NL-1:0]  src_sel = '0;
    logic [NL-1:0]  line_en = '1;
    logic [2:0]     prio_b [NL];
    logic [NL*PW-1:0] line_prio;
    logic           cpu_ack = 1'b0;
    logic           cpu_eoi = 1'b0;
    logic           irq;
    logic [4:0]     irq_num;
    logic           act_valid;
    logic [4:0]     act_num;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    for (genvar g = 0; g < NL; g++) begin : g_prio
        assign line_prio[g*PW +: PW] = prio_b[g];
    end

    irq_pend_post_ctrl #(.N_LINES(NL), .PRIO_W(PW)) dut_i (
        .clk(clk), .rst_n(rst_n), .src_fixed(src_fixed), .src_dma(src_dma),
        .src_sel(src_sel), .line_en(line_en), .line_prio(line_prio),
        .cpu_ack(cpu_ack), .cpu_eoi(cpu_eoi), .irq(irq), .irq_num(irq_num),
        .act_valid(act_valid), .act_num(act_num)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Raise a source for one cycle; leaves the bench one falling edge later
    task automatic pulse(input int line, input bit dma);
        if (dma) src_dma[line] = 1'b1; else src_fixed[line] = 1'b1;
        tick(1);
        src_dma[line] = 1'b0;
        src_fixed[line] = 1'b0;
    endtask

    task automatic ack();
        cpu_ack = 1'b1; tick(1); cpu_ack = 1'b0;
    endtask

    task automatic eoi();
        cpu_eoi = 1'b1; tick(1); cpu_eoi = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL R10 watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin : main
        for (int i = 0; i < NL; i++) prio_b[i] = 3'd7;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        chk("R10 irq after reset", irq, 0);
        chk("R10 act_valid after reset", act_valid, 0);

        // Vector table: selector, staging, acknowledge, end-of-interrupt
        for (int v = 0; v < NV; v++) begin
            src_sel[VEC[v].line] = VEC[v].sel;
            prio_b[VEC[v].line]  = VEC[v].prio;
            tick(1);
            pulse(VEC[v].line, !VEC[v].sel);
            tick(4);
            chk("R3 unselected source ignored", irq, 0);
            pulse(VEC[v].line, VEC[v].sel);
            tick(1);
            chk("R2 no irq after two edges", irq, 0);
            tick(1);
            chk("R1 irq after third edge", irq, 1);
            chk("R2 irq_num", irq_num, VEC[v].line);
            ack();
            chk("R6 irq dropped on ack", irq, 0);
            chk("R6 act_valid", act_valid, 1);
            chk("R6 act_num", act_num, VEC[v].line);
            eoi();
            chk("R9 act_valid after eoi", act_valid, 0);
            prio_b[VEC[v].line] = 3'd7;
            src_sel[VEC[v].line] = 1'b0;
        end

        // R4: tie at equal priority goes to the lower line
        src_fixed[12] = 1'b1; src_fixed[4] = 1'b1;
        tick(1);
        src_fixed = '0;
        tick(2);
        chk("R4 tie irq", irq, 1);
        chk("R4 tie goes to lower line", irq_num, 4);
        ack();
        tick(1);
        chk("R8 equal priority blocked", irq, 0);
        eoi();
        chk("R8 still blocked at pop edge", irq, 0);
        tick(1);
        chk("R9 request after pop", irq, 1);
        chk("R4 second line", irq_num, 12);
        ack(); eoi();

        // R4: more urgent priority wins over lower index
        prio_b[3] = 3'd5; prio_b[20] = 3'd1;
        src_fixed[3] = 1'b1; src_fixed[20] = 1'b1;
        tick(1);
        src_fixed = '0;
        tick(2);
        chk("R4 urgent line wins", irq_num, 20);
        ack();
        tick(1);
        chk("R8 less urgent blocked", irq, 0);
        eoi();
        tick(1);
        chk("R4 remaining line", irq_num, 3);
        chk("R4 remaining irq", irq, 1);
        ack(); eoi();
        prio_b[3] = 3'd7; prio_b[20] = 3'd7;

        // R5: disabled line pends but does not post
        line_en[10] = 1'b0;
        tick(1);
        pulse(10, 1'b0);
        tick(6);
        chk("R5 disabled not posted", irq, 0);
        line_en[10] = 1'b1;
        tick(1);
        chk("R5 one edge after enable", irq, 0);
        tick(1);
        chk("R5 posted after enable", irq, 1);
        chk("R5 line number", irq_num, 10);
        ack(); eoi();

        // R8/R9: nesting
        prio_b[5] = 3'd3; prio_b[6] = 3'd3; prio_b[7] = 3'd2;
        pulse(5, 1'b0);
        tick(2);
        chk("R8 first line irq", irq_num, 5);
        ack();
        pulse(6, 1'b0);
        tick(4);
        chk("R8 equal priority no preempt", irq, 0);
        pulse(7, 1'b0);
        tick(2);
        chk("R8 urgent preempts", irq, 1);
        chk("R8 urgent number", irq_num, 7);
        ack();
        chk("R6 nested active", act_num, 7);
        eoi();
        chk("R9 previous restored valid", act_valid, 1);
        chk("R9 previous restored number", act_num, 5);
        tick(1);
        chk("R8 still blocked under restored", irq, 0);
        eoi();
        chk("R9 stack empty", act_valid, 0);
        chk("R9 irq at pop edge", irq, 0);
        tick(1);
        chk("R9 waiting line posts", irq, 1);
        chk("R9 waiting line number", irq_num, 6);
        ack(); eoi();
        prio_b[5] = 3'd7; prio_b[6] = 3'd7; prio_b[7] = 3'd7;

        // R7: new edge during acknowledge re-pends
        pulse(9, 1'b0);
        tick(2);
        chk("R7 first request", irq_num, 9);
        cpu_ack = 1'b1; src_fixed[9] = 1'b1;
        tick(1);
        cpu_ack = 1'b0; src_fixed[9] = 1'b0;
        chk("R7 active", act_num, 9);
        tick(1);
        chk("R7 self not preempting", irq, 0);
        eoi();
        chk("R7 popped", act_valid, 0);
        tick(1);
        chk("R7 re-pended request", irq, 1);
        chk("R7 re-pended number", irq_num, 9);
        ack(); eoi();

        // R6: acknowledge without a request is ignored
        tick(2);
        ack();
        chk("R6 stray ack ignored", act_valid, 0);
        tick(2);
        chk("R6 stray ack no irq", irq, 0);

        // R10: reset clears a pending line
        pulse(2, 1'b0);
        rst_n = 1'b0;
        tick(2);
        rst_n = 1'b1;
        tick(4);
        chk("R10 pending cleared by reset", irq, 0);
        chk("R10 act cleared by reset", act_valid, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule